// File: doc/BRIEF.md
# Synchronous Serial Master Controller

This block is the master side of a clocked, byte-wide synchronous serial link. It generates a serial clock from the system clock through an even divider. It shifts 8-bit frames out on a data-out line, most significant bit first, and assembles the frame arriving on a data-in line into a receive register. Software-facing strobes load the transmit register and read the receive register. A busy flag and two one-cycle interrupt pulses report progress: `irq_tx` means the transmit holding register was taken into the shifter, and `irq_rx` means a frame has finished.

Two transfer styles are offered. In single mode each frame is started by hand, and writes made during a frame are dropped. In continuous mode a holding register queues the next frame, which then follows the current one with no idle serial clock between them. Each of transmit and receive can be enabled on its own. A clock-polarity bit sets the idle level of the serial clock, and a phase bit chooses whether data is sampled on the leading or on the trailing edge.

Top module: `csi_master`

## Requirements
- R1: Each frame carries 8 bits. `sdo` presents bit 7 first and bit 0 last, and the received byte is assembled with the first sampled bit as bit 7.
- R2: With `cfg_ckp`=0, `sck` idles high; with `cfg_ckp`=1 it idles low. The leading edge is the first transition away from the idle level. With `cfg_dap`=0, the first bit is on `sdo` before the first edge, both sides sample on the leading edge and change data on the trailing edge. With `cfg_dap`=1, data changes on the leading edge and is sampled on the trailing edge. Each frame has exactly 8 sampling edges.
- R3: Each `sck` half-period lasts `cfg_div` system clocks, and a value of 0 acts as 1. A single frame keeps `busy` high for exactly 16*`cfg_div` cycles. `busy` clears after the last trailing edge.
- R4: In continuous mode (`cfg_cont`=1) with transmit enabled, `irq_tx` is high for one cycle each time the holding register moves into the shifter. That cycle is the first cycle in which `busy` is high for that frame.
- R5: In single mode (`cfg_cont`=0), `irq_tx` never rises.
- R6: `irq_rx` is a one-cycle pulse in the cycle after a frame's last clock. In single mode it fires for every frame whatever the enables are. In continuous mode it fires only when receive is enabled.
- R7: When receive is enabled, `rx_data` holds the new byte in the same cycle that `irq_rx` is high. When receive is disabled, `rx_data` keeps its value.
- R8: In single mode, a `tx_wr` while `busy` is high is ignored. The frame in progress keeps its data and its length, and no further frame follows.
- R9: In continuous mode, a write while the shifter is busy and the holding register is empty is queued. The queued frame starts back to back, so `busy` never drops between frames, and its `irq_tx` falls in the same cycle as the previous frame's `irq_rx`. A write made while the holding register is already full is dropped.
- R10: In receive-only mode (`cfg_rx_en`=1, `cfg_tx_en`=0), `sdo` stays high and `tx_wr` starts nothing. An `rx_rd` starts a frame when the block is idle in single mode, and queues a frame like a write in continuous mode.
- R11: `sdo` is high whenever no frame is in progress.
- R12: While `rst_n` is low, the block clears `busy`, `rx_data`, any queued frame and both interrupts at the next clock, and `sck` returns to its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_cont | input | 1 | 1 = continuous transfers, 0 = single transfers |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_ckp | input | 1 | Clock polarity: 0 idle high, 1 idle low |
| cfg_dap | input | 1 | Data phase: 0 sample on leading edge, 1 on trailing edge |
| cfg_div | input | DIV_W | System clocks per serial half-period |
| tx_wr | input | 1 | Write strobe for the transmit register |
| tx_data | input | DATA_W | Byte to transmit |
| rx_rd | input | 1 | Read strobe for the receive register |
| rx_data | output | DATA_W | Last received byte |
| busy | output | 1 | Frame in progress |
| irq_tx | output | 1 | Holding register taken into shifter (continuous mode) |
| irq_rx | output | 1 | End of frame |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
In continuous mode, the end of one frame and the start of the queued one happen on the same clock edge. This makes `irq_rx` for the finished frame and `irq_tx` for the new one rise in the same cycle. The bench provokes this by writing a second byte while the first frame is still shifting, and then a third as soon as the holding register empties. It judges the result by counting cycles in which both pulses are high, by requiring one unbroken `busy` interval of three frame lengths, and by comparing the bytes that the bench's serial slave model captured with the bytes written. A write aimed at the already-full holding register checks that the queue drops data rather than overwriting it.

// File: rtl/csi_pkg.sv
// Shared definitions for the synchronous serial master.
// Assumes: configuration fields are held steady while a frame is in progress.
package csi_pkg;

    localparam int FRAME_BITS = 8;

    // Operating mode gathered from the configuration pins.
    typedef struct packed {
        logic cont;   // continuous transfers when set
        logic tx_en;  // transmit enabled
        logic rx_en;  // receive enabled
        logic ckp;    // clock polarity: 0 idle high, 1 idle low
        logic dap;    // data phase: 0 leading-edge sample, 1 trailing-edge sample
    } csi_mode_t;

endpackage

// File: rtl/csi_halfclk.sv
// Half-period timer: emits a one-cycle tick at the end of each serial clock
// half-period while running. The period is div system clocks; 0 counts as 1.
// Assumes: run rises on the cycle a frame starts, so the count starts from zero.
module csi_halfclk #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    // Effective divider, with zero treated as one.
    always_comb lim = (div == '0) ? DIV_W'(1) : div;

    // End of the half-period.
    always_comb tick = run && (cnt == lim - DIV_W'(1));

    // Count system clocks within the current half-period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + DIV_W'(1);
    end

endmodule

// File: rtl/csi_shifter.sv
// Shift engine: walks 2*DATA_W half-periods per frame. Input is captured at
// the end of each even half and shifted in at the end of each odd half.
// The output MSB therefore changes at even-half starts, and the input is
// sampled at odd-half starts. A load restarts the frame from half 0.
// Assumes: load has priority and may coincide with frame_done (back to back).
module csi_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              tick,
    input  logic              rx_keep,
    input  logic              sdi,
    output logic              active,
    output logic              phase,
    output logic              sout,
    output logic              frame_done,
    output logic [DATA_W-1:0] rx_word
);

    localparam int HALVES = 2 * DATA_W;
    localparam int HW     = $clog2(HALVES);
    localparam logic [HW-1:0] LAST = HW'(HALVES - 1);

    logic [HW-1:0]     half;
    logic [DATA_W-1:0] sreg;
    logic              cap;

    // Frame ends at the tick that closes the last half-period.
    always_comb frame_done = active && tick && (half == LAST);
    // Word as it stands after the final shift.
    always_comb rx_word = {sreg[DATA_W-2:0], cap};
    always_comb phase = half[0];
    always_comb sout = sreg[DATA_W-1];

    // Sequence halves, capture input and shift the register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            half   <= '0;
            sreg   <= '0;
            cap    <= 1'b0;
        end else if (load) begin
            active <= 1'b1;
            half   <= '0;
            sreg   <= load_data;
            cap    <= 1'b0;
        end else if (active && tick) begin
            half <= half + HW'(1);
            if (!half[0]) cap  <= rx_keep & sdi;
            else          sreg <= {sreg[DATA_W-2:0], cap};
            if (half == LAST) active <= 1'b0;
        end
    end

endmodule

// File: rtl/csi_ctrl.sv
// Transfer control: decides when a frame starts in single and continuous
// modes, keeps the one-deep holding register, produces both interrupt
// pulses and owns the receive register.
// Assumes: mode is static while a frame is running or queued.
module csi_ctrl
    import csi_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  csi_mode_t         mode,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_rd,
    input  logic              active,
    input  logic              frame_done,
    input  logic [DATA_W-1:0] rx_word,
    output logic              load,
    output logic [DATA_W-1:0] load_data,
    output logic              irq_tx,
    output logic              irq_rx,
    output logic [DATA_W-1:0] rx_data
);

    logic              rx_only;
    logic              req;
    logic              hold_v;
    logic [DATA_W-1:0] hold_d;
    logic              cont_load;
    logic              sgl_load;
    logic              accept;

    // Request decode: a write when transmitting, a read when receive-only.
    always_comb begin
        rx_only   = mode.rx_en & ~mode.tx_en;
        req       = (tx_wr & mode.tx_en) | (rx_rd & rx_only);
        cont_load = mode.cont & hold_v & (~active | frame_done);
        sgl_load  = ~mode.cont & req & ~active;
        load      = cont_load | sgl_load;
        load_data = mode.cont ? hold_d : tx_data;
        accept    = mode.cont & req & (~hold_v | cont_load);
    end

    // Holding register for continuous mode; a full register drops writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v <= 1'b0;
            hold_d <= '0;
        end else begin
            if (accept)         hold_v <= 1'b1;
            else if (cont_load) hold_v <= 1'b0;
            if (accept) hold_d <= tx_data;
        end
    end

    // Interrupt pulses and receive register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_tx  <= 1'b0;
            irq_rx  <= 1'b0;
            rx_data <= '0;
        end else begin
            irq_tx <= cont_load & mode.tx_en;
            irq_rx <= frame_done & (mode.rx_en | ~mode.cont);
            if (frame_done && mode.rx_en) rx_data <= rx_word;
        end
    end

endmodule

// File: rtl/csi_master.sv
// Synchronous serial master top: gathers configuration, instantiates the
// half-period timer, the shift engine and the transfer control, and forms
// the serial clock and data-out levels.
// Assumes: sdi is already synchronous to clk (it changes a half-period away
// from the capture point).
module csi_master
    import csi_pkg::*;
#(
    parameter int DATA_W = FRAME_BITS,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cont,
    input  logic              cfg_tx_en,
    input  logic              cfg_rx_en,
    input  logic              cfg_ckp,
    input  logic              cfg_dap,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              busy,
    output logic              irq_tx,
    output logic              irq_rx,
    output logic              sck,
    output logic              sdo,
    input  logic              sdi
);

    csi_mode_t         mode;
    logic              tick;
    logic              active;
    logic              phase;
    logic              sout;
    logic              frame_done;
    logic              load;
    logic [DATA_W-1:0] load_data;
    logic [DATA_W-1:0] rx_word;

    // Pack configuration pins into the mode record.
    always_comb mode = '{cont: cfg_cont, tx_en: cfg_tx_en, rx_en: cfg_rx_en,
                         ckp: cfg_ckp, dap: cfg_dap};

    csi_halfclk #(.DIV_W(DIV_W)) u_half (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (active),
        .div   (cfg_div),
        .tick  (tick)
    );

    csi_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_data  (load_data),
        .tick       (tick),
        .rx_keep    (cfg_rx_en),
        .sdi        (sdi),
        .active     (active),
        .phase      (phase),
        .sout       (sout),
        .frame_done (frame_done),
        .rx_word    (rx_word)
    );

    csi_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .tx_wr      (tx_wr),
        .tx_data    (tx_data),
        .rx_rd      (rx_rd),
        .active     (active),
        .frame_done (frame_done),
        .rx_word    (rx_word),
        .load       (load),
        .load_data  (load_data),
        .irq_tx     (irq_tx),
        .irq_rx     (irq_rx),
        .rx_data    (rx_data)
    );

    // Clock is away from idle in odd halves (dap=0) or even halves (dap=1);
    // data out is high unless a transmitting frame is running.
    always_comb begin
        busy = active;
        sck  = ~mode.ckp ^ (active & (phase ^ mode.dap));
        sdo  = (active & mode.tx_en) ? sout : 1'b1;
    end

endmodule

// File: rtl/csi_master_chk.sv
// Property checker for csi_master, attached through bind below.
// Assumes: rst_n is low at the first clock edge.
module csi_master_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_cont,
    input logic cfg_tx_en,
    input logic cfg_rx_en,
    input logic cfg_ckp,
    input logic busy,
    input logic irq_tx,
    input logic irq_rx,
    input logic sck,
    input logic sdo
);

    // R12: reset quiets busy and both interrupts by the next edge.
    p_reset_quiet_r12: assert property (@(posedge clk)
        !rst_n |=> (!busy && !irq_tx && !irq_rx));

    // R5: a transmit interrupt only follows a cycle of continuous mode.
    p_tx_irq_cont_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |-> $past(cfg_cont));

    // R4: the transmit interrupt marks the start of a frame.
    p_tx_irq_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |-> busy);

    // R4: the transmit interrupt is one cycle wide.
    p_tx_irq_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |=> !irq_tx);

    // R6: the receive interrupt is one cycle wide.
    p_rx_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |=> !irq_rx);

    // R6: the receive interrupt only follows a cycle with a frame running.
    p_rx_irq_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |-> $past(busy));

    // R2: the serial clock rests at its idle level between frames.
    p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sck != cfg_ckp));

    // R10: receive-only mode keeps data out high.
    p_sdo_rx_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rx_en && !cfg_tx_en) |-> sdo);

    // R11: data out is high while idle.
    p_sdo_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sdo);

endmodule

bind csi_master csi_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_cont  (cfg_cont),
    .cfg_tx_en (cfg_tx_en),
    .cfg_rx_en (cfg_rx_en),
    .cfg_ckp   (cfg_ckp),
    .busy      (busy),
    .irq_tx    (irq_tx),
    .irq_rx    (irq_rx),
    .sck       (sck),
    .sdo       (sdo)
);

// File: tb/sim_csi_master.sv
// Bench for csi_master: sweeps clock types, dividers and modes, with a
// behavioural serial slave that streams known bytes and captures sdo.
module sim_csi_master;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_cont = 1'b0, cfg_tx_en = 1'b1, cfg_rx_en = 1'b1;
    logic       cfg_ckp = 1'b0, cfg_dap = 1'b0;
    logic [7:0] cfg_div = 8'd1;
    logic       tx_wr = 1'b0, rx_rd = 1'b0, sdi = 1'b1;
    logic [7:0] tx_data = 8'h00;
    logic [7:0] rx_data;
    logic       busy, irq_tx, irq_rx, sck, sdo;

    always #4 clk = ~clk;

    csi_master u0 (
        .clk(clk), .rst_n(rst_n), .cfg_cont(cfg_cont), .cfg_tx_en(cfg_tx_en),
        .cfg_rx_en(cfg_rx_en), .cfg_ckp(cfg_ckp), .cfg_dap(cfg_dap),
        .cfg_div(cfg_div), .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd),
        .rx_data(rx_data), .busy(busy), .irq_tx(irq_tx), .irq_rx(irq_rx),
        .sck(sck), .sdo(sdo), .sdi(sdi)
    );

    int  checks = 0, fails = 0;
    bit  done = 1'b0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Serial slave model.
    bit         slv_on = 1'b0;
    int         slv_n = 0, cap_cnt = 0;
    logic [7:0] cap_sh = 8'h00, slv_seed = 8'h00;
    logic [7:0] cap_log [0:7];

    function automatic logic [7:0] sbyte(input int k);
        return slv_seed + 8'(k) * 8'h47;
    endfunction

    function automatic logic sbit(input int n);
        logic [7:0] b;
        b = sbyte(n / 8);
        return b[7 - (n % 8)];
    endfunction

    always @(sck) begin
        if (slv_on) begin
            if ((sck == cfg_ckp) ^ cfg_dap) begin
                cap_sh = {cap_sh[6:0], sdo};
                cap_cnt++;
                if (cap_cnt % 8 == 0) cap_log[(cap_cnt / 8 - 1) % 8] = cap_sh;
            end else if (!cfg_dap) begin
                slv_n++;
                sdi = sbit(slv_n);
            end else begin
                sdi = sbit(slv_n);
                slv_n++;
            end
        end
    end

    // Output monitor, sampled on the falling edge.
    bit         mon_on = 1'b0;
    int         busy_cyc = 0, busy_falls = 0, ntx = 0, nrx = 0, ncoin = 0, sdo_low = 0;
    logic       prev_busy = 1'b0;
    logic [7:0] rx_log [0:7];

    always @(negedge clk) begin
        if (mon_on) begin
            if (busy) busy_cyc++;
            if (prev_busy && !busy) busy_falls++;
            prev_busy = busy;
            if (irq_tx) ntx++;
            if (irq_rx) begin
                rx_log[nrx % 8] = rx_data;
                nrx++;
            end
            if (irq_tx && irq_rx) ncoin++;
            if (busy && !sdo) sdo_low++;
        end
    end

    task automatic start_case(input logic ckp, input logic dap, input logic [7:0] div,
                              input logic cont, input logic txe, input logic rxe,
                              input logic [7:0] seed);
        @(negedge clk);
        slv_on = 1'b0;
        mon_on = 1'b0;
        cfg_ckp = ckp; cfg_dap = dap; cfg_div = div;
        cfg_cont = cont; cfg_tx_en = txe; cfg_rx_en = rxe;
        @(negedge clk);
        slv_seed = seed; slv_n = 0; cap_cnt = 0; cap_sh = 8'h00;
        sdi = sbit(0);
        busy_cyc = 0; busy_falls = 0; ntx = 0; nrx = 0; ncoin = 0; sdo_low = 0;
        prev_busy = 1'b0;
        slv_on = 1'b1;
        mon_on = 1'b1;
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        tx_wr = 1'b1; tx_data = d;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic rd_pulse();
        @(negedge clk);
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic wait_ntx(input int n);
        while (ntx < n) begin
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, keep;
        int idx;
        repeat (3) @(negedge clk);
        // R12 / R11: state under reset.
        chk("R12", "busy in reset", busy, 0);
        chk("R12", "irq_tx in reset", irq_tx, 0);
        chk("R12", "irq_rx in reset", irq_rx, 0);
        chk("R12", "rx_data in reset", rx_data, 0);
        chk("R12", "sck idle in reset", sck, 1);
        chk("R11", "sdo idle in reset", sdo, 1);
        rst_n = 1'b1;

        // Single full-duplex sweep over clock types and dividers (R1,R2,R3,R5,R6,R7,R8).
        idx = 0;
        for (int c = 0; c < 4; c++) begin
            for (int dv = 1; dv <= 3; dv++) begin
                start_case(c[1], c[0], 8'(dv), 1'b0, 1'b1, 1'b1, 8'(8'h1D + idx * 13));
                d = 8'hC3 ^ 8'(idx * 29);
                wr(d);
                if (idx == 5) begin
                    repeat (3) @(negedge clk);
                    tx_wr = 1'b1; tx_data = ~d;
                    @(negedge clk);
                    tx_wr = 1'b0;
                end
                wait_idle();
                chk("R3", "busy length", busy_cyc, 16 * dv);
                chk("R8", "single busy intervals", busy_falls, 1);
                chk("R1", "captured tx byte", cap_log[0], d);
                chk("R2", "sampling edges", cap_cnt, 8);
                chk("R7", "received byte at irq", rx_log[0], sbyte(0));
                chk("R6", "single irq_rx count", nrx, 1);
                chk("R5", "single irq_tx count", ntx, 0);
                chk("R2", "sck idle level", sck, !c[1]);
                chk("R11", "sdo idle", sdo, 1);
                idx++;
            end
        end

        // Continuous full duplex, back to back with a dropped write (R4,R9).
        for (int c = 0; c < 4; c++) begin
            start_case(c[1], c[0], 8'd2, 1'b1, 1'b1, 1'b1, 8'(8'h61 + c * 7));
            wr(8'h5A + 8'(c));
            wait_ntx(1);
            wr(8'hA1 + 8'(c));
            wr(8'hEE);
            wait_ntx(2);
            wr(8'h3C + 8'(c));
            wait_idle();
            chk("R9", "continuous busy length", busy_cyc, 3 * 32);
            chk("R9", "one busy interval", busy_falls, 1);
            chk("R4", "irq_tx count", ntx, 3);
            chk("R6", "continuous rx irq count", nrx, 3);
            chk("R9", "irq_tx with irq_rx", ncoin, 2);
            chk("R9", "frame 0 data", cap_log[0], 8'h5A + 8'(c));
            chk("R9", "frame 1 data", cap_log[1], 8'hA1 + 8'(c));
            chk("R9", "frame 2 data", cap_log[2], 8'h3C + 8'(c));
            chk("R7", "rx frame 1", rx_log[1], sbyte(1));
            chk("R7", "rx frame 2", rx_log[2], sbyte(2));
        end

        // Transmit-only single: irq_rx still fires, rx_data kept (R6,R7).
        keep = rx_data;
        start_case(1'b0, 1'b1, 8'd0, 1'b0, 1'b1, 1'b0, 8'h99);
        wr(8'h81);
        wait_idle();
        chk("R6", "tx-only single irq_rx", nrx, 1);
        chk("R7", "tx-only rx_data kept", rx_data, keep);
        chk("R3", "div zero acts as one", busy_cyc, 16);
        chk("R1", "tx-only data", cap_log[0], 8'h81);

        // Transmit-only continuous: no irq_rx (R6,R4).
        start_case(1'b1, 1'b0, 8'd1, 1'b1, 1'b1, 1'b0, 8'h42);
        wr(8'h7E);
        wait_idle();
        chk("R6", "tx-only continuous irq_rx", nrx, 0);
        chk("R4", "tx-only continuous irq_tx", ntx, 1);
        chk("R7", "tx-only continuous rx_data kept", rx_data, keep);

        // Receive-only single (R10).
        start_case(1'b1, 1'b0, 8'd2, 1'b0, 1'b0, 1'b1, 8'hB4);
        wr(8'h00);
        repeat (4) @(negedge clk);
        #1;
        chk("R10", "tx_wr starts nothing", busy_cyc, 0);
        rd_pulse();
        wait_idle();
        chk("R10", "rx-only frame length", busy_cyc, 32);
        chk("R10", "sdo held high", sdo_low, 0);
        chk("R10", "rx-only byte", rx_log[0], sbyte(0));
        chk("R5", "rx-only irq_tx", ntx, 0);

        // Receive-only continuous, two queued reads (R10,R9).
        start_case(1'b0, 1'b1, 8'd1, 1'b1, 1'b0, 1'b1, 8'h0F);
        rd_pulse();
        repeat (3) @(negedge clk);
        rd_pulse();
        wait_idle();
        chk("R10", "rx-only continuous length", busy_cyc, 32);
        chk("R9", "rx-only continuous one interval", busy_falls, 1);
        chk("R10", "rx-only continuous byte 0", rx_log[0], sbyte(0));
        chk("R10", "rx-only continuous byte 1", rx_log[1], sbyte(1));
        chk("R10", "rx-only continuous sdo", sdo_low, 0);
        chk("R4", "rx-only continuous irq_tx", ntx, 0);

        // Reset in the middle of a frame (R12).
        start_case(1'b0, 1'b0, 8'd3, 1'b0, 1'b1, 1'b1, 8'h21);
        wr(8'h96);
        repeat (10) @(negedge clk);
        slv_on = 1'b0;
        mon_on = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk("R12", "busy after mid reset", busy, 0);
        chk("R12", "rx_data after mid reset", rx_data, 0);
        chk("R12", "sck after mid reset", sck, 1);
        chk("R12", "irq_rx after mid reset", irq_rx, 0);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        #1;
        chk("R12", "no frame resumes after reset", busy, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule